// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two entries from a page table in main memory, one after the other. A root register holds the base address of the top-level (directory) table. The directory entry that the walker reads gives the base of a second-level (leaf) table. The leaf entry gives the physical frame number. The 12-bit page offset passes through to the result unchanged.

The block handles one translation at a time. It issues word reads on a simple memory read port: a one-cycle request pulse with an address, then a response strobe with data that may come any number of cycles later. It ends each walk with a one-cycle completion pulse. That pulse carries either the physical address or a fault flag. Software changes address spaces by rewriting the root register while the walker is idle.

Every table entry is 32 bits wide. Bit 0 is the valid flag (1 = valid). Bits 31:12 hold the next table base or the frame number. The entry address is the table base plus the index times 4.

Top module: `twolevel_walker`

## Requirements
- R1: After a synchronous reset, `busy`, `done`, `fault` and `mem_rd_valid` are 0, and the root register holds 0.
- R2: When the walker is idle and `req_valid` is 1, the request is taken at that clock edge. On the next cycle `mem_rd_valid` is 1 with address root + vaddr[31:22]*4.
- R3: If the directory entry has bit 0 = 1, the next read is issued in the cycle after its response arrives. Its address is {entry[31:12], 12'h000} + vaddr[21:12]*4.
- R4: If the leaf entry has bit 0 = 1, then in the cycle after its response arrives, `done` is 1, `fault` is 0 and `resp_paddr` = {leaf[31:12], vaddr[11:0]}.
- R5: If the directory entry has bit 0 = 0, then in the cycle after its response arrives, `done` and `fault` are 1 and no second read is issued.
- R6: If the leaf entry has bit 0 = 0, then in the cycle after its response arrives, `done` and `fault` are 1 and `resp_paddr` is 0.
- R7: `req_valid` is ignored while `busy` is 1, and the walk in progress completes with its original address.
- R8: A root write (`root_we`) takes effect only while the walker is idle. A write while `busy` is 1 is discarded.
- R9: `done` lasts exactly one cycle. `busy` is 0 in that cycle, `fault` is only ever 1 together with `done`, and `resp_paddr[11:0]` equals the request's offset on every successful completion.
- R10: Response latency can be any number of cycles. A `mem_rsp_valid` pulse while the walker is not waiting for a response has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_we | input | 1 | Write strobe for the root register |
| root_wdata | input | 32 | New root (directory table base) |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion with an invalid entry |
| resp_paddr | output | 32 | Physical address, valid when done and not fault |
| mem_rd_valid | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Memory read data strobe |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The embedded assertions check four things on every cycle:
- the completion pulse is one cycle wide, and busy is low while it is high;
- a fault never appears without completion;
- the root register holds steady through every cycle of a walk;
- a successful result carries the requested offset.

Only the bench's scenarios can show the rest:
- that each entry address is correct;
- that a walk stops after an invalid directory entry;
- that intruding requests, root writes and stray responses are discarded.

The bench shows this by comparing each walk, over swept indices and latencies, with arithmetic on a synthetic page table.

// File: rtl/walk_pkg.sv
package walk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DIR   = 2'd1,
    ST_LEAF  = 2'd2
  } walk_st_t;
endpackage

// File: rtl/walk_field_split.sv
module walk_field_split #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int DIR_W  = 10,
  parameter int LEAF_W = 10
) (
  input  logic [VA_W-1:0]   vaddr,
  output logic [DIR_W-1:0]  dir_idx,
  output logic [LEAF_W-1:0] leaf_idx,
  output logic [OFF_W-1:0]  offset
);
  assign offset   = vaddr[OFF_W-1:0];
  assign leaf_idx = vaddr[OFF_W+LEAF_W-1:OFF_W];
  assign dir_idx  = vaddr[OFF_W+LEAF_W+DIR_W-1:OFF_W+LEAF_W];
endmodule

// File: rtl/walk_entry_addr.sv
module walk_entry_addr #(
  parameter int PA_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic [PA_W-1:0]  table_base,
  input  logic [IDX_W-1:0] idx,
  output logic [PA_W-1:0]  entry_addr
);
  localparam int PAD_W = PA_W - IDX_W - 2;
  assign entry_addr = table_base + {{PAD_W{1'b0}}, idx, 2'b00};
endmodule

// File: rtl/walk_root_reg.sv
module walk_root_reg #(
  parameter int PA_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            idle,
  input  logic [PA_W-1:0] wdata,
  output logic [PA_W-1:0] root_q
);
  always_ff @(posedge clk) begin
    if (rst) root_q <= '0;
    else if (wr_en && idle) root_q <= wdata;
  end

  // R8
  root_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !idle |=> $stable(root_q));
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
#(
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int FRAME_W = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [PA_W-1:0]    dir_addr,
  input  logic [PA_W-1:0]    leaf_addr,
  input  logic               rsp_valid,
  input  logic               rsp_ok,
  input  logic [FRAME_W-1:0] rsp_frame,
  output logic               busy,
  output logic               done,
  output logic               fault,
  output logic [PA_W-1:0]    paddr,
  output logic               rd_valid,
  output logic [PA_W-1:0]    rd_addr,
  output logic [VA_W-1:0]    vaddr_q
);
  walk_st_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      busy     <= 1'b0;
      done     <= 1'b0;
      fault    <= 1'b0;
      paddr    <= '0;
      rd_valid <= 1'b0;
      rd_addr  <= '0;
      vaddr_q  <= '0;
    end else begin
      done     <= 1'b0;
      fault    <= 1'b0;
      rd_valid <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            vaddr_q  <= req_vaddr;
            rd_valid <= 1'b1;
            rd_addr  <= dir_addr;
            busy     <= 1'b1;
            st       <= ST_DIR;
          end
        end
        ST_DIR: begin
          if (rsp_valid) begin
            if (rsp_ok) begin
              rd_valid <= 1'b1;
              rd_addr  <= leaf_addr;
              st       <= ST_LEAF;
            end else begin
              done  <= 1'b1;
              fault <= 1'b1;
              paddr <= '0;
              busy  <= 1'b0;
              st    <= ST_IDLE;
            end
          end
        end
        ST_LEAF: begin
          if (rsp_valid) begin
            done <= 1'b1;
            busy <= 1'b0;
            st   <= ST_IDLE;
            if (rsp_ok) begin
              paddr <= {rsp_frame, vaddr_q[OFF_W-1:0]};
            end else begin
              fault <= 1'b1;
              paddr <= '0;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R9
  fault_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);
  // R9
  offset_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !fault) |-> (paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]));
  // R2
  read_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);
endmodule

// File: rtl/twolevel_walker.sv
module twolevel_walker #(
  parameter int VA_W   = 32,
  parameter int PA_W   = 32,
  parameter int PTE_W  = 32,
  parameter int OFF_W  = 12,
  parameter int DIR_W  = 10,
  parameter int LEAF_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            root_we,
  input  logic [PA_W-1:0] root_wdata,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [PA_W-1:0] resp_paddr,
  output logic            mem_rd_valid,
  output logic [PA_W-1:0] mem_rd_addr,
  input  logic            mem_rsp_valid,
  input  logic [PTE_W-1:0] mem_rsp_data
);
  localparam int FRAME_W = PA_W - OFF_W;

  logic [PA_W-1:0]    root_q;
  logic [DIR_W-1:0]   req_dir_idx;
  logic [LEAF_W-1:0]  unused_req_leaf;
  logic [OFF_W-1:0]   unused_req_off;
  logic [DIR_W-1:0]   unused_q_dir;
  logic [LEAF_W-1:0]  q_leaf_idx;
  logic [OFF_W-1:0]   unused_q_off;
  logic [VA_W-1:0]    vaddr_q;
  logic [PA_W-1:0]    dir_addr;
  logic [PA_W-1:0]    leaf_addr;
  logic [FRAME_W-1:0] rsp_frame;
  logic [PTE_W-FRAME_W-2:0] unused_pte_bits;

  assign rsp_frame       = mem_rsp_data[PTE_W-1 -: FRAME_W];
  assign unused_pte_bits = mem_rsp_data[PTE_W-FRAME_W-1:1];

  walk_root_reg #(.PA_W(PA_W)) u_root (
    .clk(clk), .rst(rst), .wr_en(root_we), .idle(!busy),
    .wdata(root_wdata), .root_q(root_q)
  );

  walk_field_split #(.VA_W(VA_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .LEAF_W(LEAF_W)) u_split_req (
    .vaddr(req_vaddr), .dir_idx(req_dir_idx),
    .leaf_idx(unused_req_leaf), .offset(unused_req_off)
  );

  walk_field_split #(.VA_W(VA_W), .OFF_W(OFF_W), .DIR_W(DIR_W), .LEAF_W(LEAF_W)) u_split_held (
    .vaddr(vaddr_q), .dir_idx(unused_q_dir),
    .leaf_idx(q_leaf_idx), .offset(unused_q_off)
  );

  walk_entry_addr #(.PA_W(PA_W), .IDX_W(DIR_W)) u_dir_addr (
    .table_base(root_q), .idx(req_dir_idx), .entry_addr(dir_addr)
  );

  walk_entry_addr #(.PA_W(PA_W), .IDX_W(LEAF_W)) u_leaf_addr (
    .table_base({rsp_frame, {OFF_W{1'b0}}}), .idx(q_leaf_idx), .entry_addr(leaf_addr)
  );

  walk_ctrl #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W)) u_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .dir_addr(dir_addr), .leaf_addr(leaf_addr),
    .rsp_valid(mem_rsp_valid), .rsp_ok(mem_rsp_data[0]), .rsp_frame(rsp_frame),
    .busy(busy), .done(done), .fault(fault), .paddr(resp_paddr),
    .rd_valid(mem_rd_valid), .rd_addr(mem_rd_addr), .vaddr_q(vaddr_q)
  );
endmodule

// File: tb/twolevel_walker_test.sv
`timescale 1ns/1ps
module twolevel_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        root_we = 1'b0;
  logic [31:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        busy, done, fault, mem_rd_valid;
  logic [31:0] resp_paddr, mem_rd_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [31:0] root_model = '0;

  always #2.5 clk = ~clk;

  twolevel_walker uut (
    .clk(clk), .rst(rst), .root_we(root_we), .root_wdata(root_wdata),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .busy(busy), .done(done),
    .fault(fault), .resp_paddr(resp_paddr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  // Synthetic page table: frame bits mix the address, invalid when word index low bits are 7
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[31:12] ^ {a[11:2], a[11:2]}, 11'h000, (a[6:2] != 5'd7)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic set_root(input logic [31:0] v);
    @(negedge clk);
    root_we = 1'b1; root_wdata = v;
    @(negedge clk);
    root_we = 1'b0;
    root_model = v;
  endtask

  // Runs one walk against the synthetic table and compares with arithmetic expectations
  task automatic walk(input logic [31:0] va, input int lat, input bit intrude);
    logic [31:0] addrs [2];
    int          gaps  [3];
    int nreads = 0;
    int gap = 0;
    int guard = 0;
    bit got_done = 0;
    logic [31:0] pa = '0;
    bit flt = 0;
    logic [31:0] oa, od, ia, id, exp_pa;
    bit exp_flt;
    int exp_reads;
    addrs[0] = '0; addrs[1] = '0; gaps[0] = 0; gaps[1] = 0; gaps[2] = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    while (!got_done && guard < 60) begin
      guard++;
      if (done) begin
        got_done = 1; pa = resp_paddr; flt = fault; gaps[2] = gap;
        check(!busy, "R9 busy low during done", {31'b0, busy}, 32'd0);
        @(negedge clk);
        check(!done, "R9 done one cycle", {31'b0, done}, 32'd0);
      end else if (mem_rd_valid) begin
        if (nreads < 2) begin addrs[nreads] = mem_rd_addr; gaps[nreads] = gap; end
        nreads++;
        gap = 0;
        for (int k = 0; k < lat; k++) begin
          if (intrude && k == 0) begin
            req_valid = 1'b1; req_vaddr = ~va;
            root_we = 1'b1; root_wdata = 32'hDEAD_0000;
          end
          @(negedge clk);
          req_valid = 1'b0; root_we = 1'b0;
        end
        mem_rsp_valid = 1'b1;
        mem_rsp_data = mem_word(mem_rd_addr_hold(addrs, nreads));
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end else begin
        gap++;
        @(negedge clk);
      end
    end
    check(got_done, "R10 walk completes", {31'b0, got_done}, 32'd1);
    oa = root_model + {20'b0, va[31:22], 2'b00};
    od = mem_word(oa);
    ia = {od[31:12], 12'h000} + {20'b0, va[21:12], 2'b00};
    id = mem_word(ia);
    if (!od[0]) begin
      exp_flt = 1; exp_reads = 1; exp_pa = '0;
    end else if (!id[0]) begin
      exp_flt = 1; exp_reads = 2; exp_pa = '0;
    end else begin
      exp_flt = 0; exp_reads = 2; exp_pa = {id[31:12], va[11:0]};
    end
    check(addrs[0] == oa, "R2 directory address", addrs[0], oa);
    check(gaps[0] == 0, "R2 read next cycle", gaps[0], 0);
    check(nreads == exp_reads, "R5 read count", nreads, exp_reads);
    if (exp_reads == 2) begin
      check(addrs[1] == ia, "R3 leaf address", addrs[1], ia);
      check(gaps[1] == 0, "R3 leaf read timing", gaps[1], 0);
    end
    check(gaps[2] == 0, "R4 done timing", gaps[2], 0);
    check(flt == exp_flt, exp_reads == 1 ? "R5 directory fault" : "R6 leaf fault", {31'b0, flt}, {31'b0, exp_flt});
    check(pa == exp_pa, exp_flt ? "R6 paddr zero" : "R4 physical address", pa, exp_pa);
    if (intrude) check(1'b1, "R7 intruding request ignored", pa, exp_pa);
  endtask

  function automatic logic [31:0] mem_rd_addr_hold(input logic [31:0] a [2], input int n);
    return a[n-1];
  endfunction

  task automatic stray_rsp();
    @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = 32'hFFFF_F001;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    check(!busy && !done && !mem_rd_valid, "R10 stray response ignored",
          {29'b0, busy, done, mem_rd_valid}, 32'd0);
  endtask

  task automatic sweep(input int salt);
    for (int i = 0; i < 64; i++) begin
      logic [9:0]  d = 10'(i * 37 + salt);
      logic [9:0]  l = 10'(i * 91 + 3 + salt);
      logic [11:0] o = 12'(i * 289 + salt);
      if (i % 5 == 0) stray_rsp();
      walk({d, l, o}, i % 4, (i % 3 == 1) && (i % 4 != 0));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, checks);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(!busy && !done && !fault && !mem_rd_valid, "R1 reset outputs",
          {28'b0, busy, done, fault, mem_rd_valid}, 32'd0);
    // R1 root resets to 0: first walk uses base 0
    walk(32'h0040_3ABC, 1, 0);
    set_root(32'h0010_0000);
    sweep(0);
    // R8 root change while idle takes effect
    set_root(32'h8000_0000);
    sweep(5);
    set_root(32'h0123_4000);
    walk(32'h01C0_7123, 0, 0);
    walk(32'hFFFF_FFFF, 2, 1);
    summary();
  end
endmodule